// File: doc/BRIEF.md
# Station Address PROM Access Decoder

This block is the host-facing front end for the 16-byte station address store of a network controller. Host accesses arrive with a window select: a port window or a memory-mapped window. Each access carries a size, an address, write data and a direction. Accesses to the lower half of either window address the PROM. Accesses to the upper half go out on a register-port interface to the controller's register file, which lies outside this block.

The two windows check legality differently. In the port window, the legal access sizes depend on a run-time double-word mode bit and on address alignment. In the memory-mapped window, any byte, 16-bit or 32-bit access to the lower half is accepted, and the byte index wraps inside the 16-byte store. Multi-byte data is packed and unpacked little-endian. A PROM write is dropped unless the write-enable input is high. A read that matches no legal case returns all ones in the width of the access.

Read data appears one cycle after the request, with a response strobe. A write is acknowledged combinationally in the same cycle it is presented.

Top module: `prom_access_decoder`

## Requirements
- R1: After reset every PROM byte reads as zero, and `rsp_valid` and `reg_valid` are low.
- R2: In the port window with `dword_mode` low, a lower-half access is honoured when it is a byte access (`req_size`=0), or a 16-bit access (`req_size`=1) at an even address.
- R3: In the port window with `dword_mode` high, a lower-half access is honoured only when it is a 32-bit access (`req_size`=2) whose address bits 1:0 are zero.
- R4: A honoured PROM write changes the stored bytes only while `prom_we` is high. PROM reads work regardless of `prom_we`.
- R5: A read that is neither honoured nor routed returns 0xFF for byte size, 0xFFFF for 16-bit size and 0xFFFFFFFF otherwise. A write that is neither honoured nor routed changes nothing.
- R6: Multi-byte PROM data is little-endian. The byte at the access address is bits 7:0, and each following byte takes the next higher 8 bits.
- R7: In the port window (`req_win`=0), an address with bit 4 set and a 16-bit or 32-bit size raises `reg_valid` with `reg_addr` equal to the full 5-bit address, and a read returns `reg_rdata`. A byte access there is not routed: the write is dropped and the read gives 0xFF.
- R8: In the memory-mapped window (`req_win`=1), address bit 4 set with a 16-bit or 32-bit size is routed with `reg_addr` = {0, addr[3:0]}, and a byte access there reads 0xFF. With bit 4 clear, sizes 0 to 2 reach the PROM whatever `dword_mode` is, and the byte index wraps modulo 16.
- R9: `rsp_valid` goes high exactly one cycle after each read request and stays low after writes. `wr_ack` is high in the same cycle as every write request.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low synchronous reset |
| dword_mode | input | 1 | Port window double-word mode |
| prom_we | input | 1 | PROM write enable |
| req_valid | input | 1 | Request strobe |
| req_win | input | 1 | 0 = port window, 1 = memory-mapped window |
| req_write | input | 1 | 1 = write, 0 = read |
| req_size | input | 2 | 0 byte, 1 16-bit, 2 32-bit |
| req_addr | input | 5 | Byte address within the window |
| req_wdata | input | 32 | Write data, little-endian |
| wr_ack | output | 1 | Write accepted (same cycle) |
| rsp_valid | output | 1 | Read data valid |
| rsp_rdata | output | 32 | Read data |
| reg_valid | output | 1 | Register-port access strobe |
| reg_write | output | 1 | Register-port direction |
| reg_size | output | 2 | Register-port size |
| reg_addr | output | 5 | Register-port offset |
| reg_wdata | output | 32 | Register-port write data |
| reg_rdata | input | 32 | Register-port read data (same cycle) |

## Verification
The bench builds the block with its default parameters: a 4-bit PROM index, which gives 16 bytes, and a 32-bit data path. At this size all three access widths can be tried at every offset. That includes the 16-bit access at offset 15 in the memory-mapped window, which wraps to byte 0. It also exercises both settings of the mode bit against every alignment case, and both halves of each window.

// File: rtl/prom_access_decoder.sv
module prom_access_decoder #(
  parameter int PROM_AW = 4,
  parameter int DATA_W  = 32
) (
  input  logic                clk,
  input  logic                rst_n,
  input  logic                dword_mode,
  input  logic                prom_we,
  input  logic                req_valid,
  input  logic                req_win,
  input  logic                req_write,
  input  logic [1:0]          req_size,
  input  logic [PROM_AW:0]    req_addr,
  input  logic [DATA_W-1:0]   req_wdata,
  output logic                wr_ack,
  output logic                rsp_valid,
  output logic [DATA_W-1:0]   rsp_rdata,
  output logic                reg_valid,
  output logic                reg_write,
  output logic [1:0]          reg_size,
  output logic [PROM_AW:0]    reg_addr,
  output logic [DATA_W-1:0]   reg_wdata,
  input  logic [DATA_W-1:0]   reg_rdata
);
  localparam int PROM_N = 1 << PROM_AW;
  localparam int NBYTES = DATA_W / 8;

  logic [PROM_N-1:0][7:0] prom;
  logic [DATA_W-1:0] prom_rd, ones, rd_next;
  logic [2:0] nb;

  wire upper   = req_addr[PROM_AW];
  wire reg_sz  = (req_size == 2'd1) || (req_size == 2'd2);
  wire to_reg  = upper && reg_sz;
  wire io_ok   = dword_mode ? (req_size == 2'd2 && req_addr[1:0] == 2'b00)
                            : (req_size == 2'd0 || (req_size == 2'd1 && !req_addr[0]));
  wire mm_ok   = req_size != 2'd3;
  wire prom_ok = !upper && (req_win ? mm_ok : io_ok);

  assign nb = (req_size == 2'd0) ? 3'd1 : (req_size == 2'd1) ? 3'd2 : 3'd4;

  always_comb begin
    prom_rd = '0;
    ones    = '0;
    for (int i = 0; i < NBYTES; i++) begin
      if (i < int'(nb)) begin
        prom_rd[8*i +: 8] = prom[req_addr[PROM_AW-1:0] + PROM_AW'(i)];
        ones[8*i +: 8]    = 8'hFF;
      end
    end
  end

  assign rd_next = to_reg ? reg_rdata : prom_ok ? prom_rd : ones;

  always_ff @(posedge clk) begin
    if (!rst_n) begin
      prom      <= '0;
      rsp_valid <= 1'b0;
      rsp_rdata <= '0;
    end else begin
      rsp_valid <= req_valid && !req_write;
      if (req_valid && !req_write) rsp_rdata <= rd_next;
      if (req_valid && req_write && prom_ok && prom_we)
        for (int i = 0; i < NBYTES; i++)
          if (i < int'(nb))
            prom[req_addr[PROM_AW-1:0] + PROM_AW'(i)] <= req_wdata[8*i +: 8];
    end
  end

  assign wr_ack    = req_valid && req_write;
  assign reg_valid = req_valid && to_reg;
  assign reg_write = req_write;
  assign reg_size  = req_size;
  assign reg_addr  = req_win ? {1'b0, req_addr[PROM_AW-1:0]} : req_addr;
  assign reg_wdata = req_wdata;

  p_rsp_one_cycle_r9: assert property (@(posedge clk) disable iff (!rst_n)
    rsp_valid |-> $past(req_valid && !req_write));
  p_reg_upper_only_r8: assert property (@(posedge clk) disable iff (!rst_n)
    reg_valid |-> (upper && reg_size != 2'd0));
  p_locked_prom_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !prom_we) |=> $stable(prom));
  p_dword_gate_r3: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && req_write && !req_win && dword_mode && req_size != 2'd2) |=> $stable(prom));
  p_byte_ones_r5: assert property (@(posedge clk) disable iff (!rst_n)
    (req_valid && !req_write && req_size == 2'd0 && upper) |=> (rsp_rdata == DATA_W'(8'hFF)));
endmodule

// File: tb/tb_prom_access_decoder.sv
`timescale 1ns/1ps
module tb_prom_access_decoder;
  logic clk = 0, rst_n = 0, dword_mode = 0, prom_we = 0;
  logic req_valid = 0, req_win = 0, req_write = 0;
  logic [1:0] req_size = 0;
  logic [4:0] req_addr = 0;
  logic [31:0] req_wdata = 0, reg_rdata = 0;
  logic wr_ack, rsp_valid, reg_valid, reg_write;
  logic [1:0] reg_size;
  logic [4:0] reg_addr;
  logic [31:0] rsp_rdata, reg_wdata;
  int checks = 0, errors = 0;
  bit done = 0;
  logic [7:0] m [16];

  always #10 clk = ~clk;

  prom_access_decoder dut (.*);

  task automatic chk(input bit ok, input string tag, input logic [31:0] act, input logic [31:0] exp);
    checks++;
    if (!ok) begin
      errors++;
      $display("FAIL %s actual=%h expected=%h", tag, act, exp);
    end
  endtask

  task automatic acc(input bit win, input bit wr, input logic [1:0] sz,
                     input logic [4:0] a, input logic [31:0] wd, input string tag);
    bit legal, toreg;
    int nb;
    logic [31:0] exp;
    logic [4:0] ra;
    nb = (sz == 0) ? 1 : (sz == 1) ? 2 : 4;
    toreg = a[4] && (sz == 1 || sz == 2);
    if (win) legal = !a[4] && sz != 3;
    else legal = !a[4] && (dword_mode ? (sz == 2 && a[1:0] == 0)
                                      : (sz == 0 || (sz == 1 && !a[0])));
    ra = win ? {1'b0, a[3:0]} : a;
    exp = 0;
    for (int i = 0; i < nb; i++)
      exp[8*i +: 8] = toreg ? 8'h00 : legal ? m[(a[3:0] + i) % 16] : 8'hFF;
    if (toreg) exp = 32'hBEEF0000 | 32'(ra);
    @(negedge clk);
    req_valid = 1; req_win = win; req_write = wr; req_size = sz;
    req_addr = a; req_wdata = wd; reg_rdata = 32'hBEEF0000 | 32'(ra);
    #1;
    chk(wr_ack == wr, {tag, " R9 wr_ack"}, 32'(wr_ack), 32'(wr));
    chk(reg_valid == toreg, {tag, " reg_valid"}, 32'(reg_valid), 32'(toreg));
    if (toreg) chk(reg_addr == ra, {tag, " reg_addr"}, 32'(reg_addr), 32'(ra));
    @(negedge clk);
    if (wr) begin
      chk(rsp_valid == 0, {tag, " R9 no rsp on write"}, 32'(rsp_valid), 0);
      if (legal && prom_we)
        for (int i = 0; i < nb; i++) m[(a[3:0] + i) % 16] = wd[8*i +: 8];
    end else begin
      chk(rsp_valid == 1, {tag, " R9 rsp_valid"}, 32'(rsp_valid), 1);
      chk(rsp_rdata == exp, {tag, " rdata"}, rsp_rdata, exp);
    end
    req_valid = 0;
  endtask

  initial begin
    #2_000_000;
    if (!done) begin
      errors++;
      $display("FAIL watchdog actual=%h expected=%h", 0, 1);
      $display("CHECKS %0d ERRORS %0d", checks, errors);
      $finish;
    end
  end

  initial begin
    for (int i = 0; i < 16; i++) m[i] = 8'h00;
    repeat (3) @(negedge clk);
    rst_n = 1;
    #1;
    chk(rsp_valid == 0 && reg_valid == 0, "R1 reset outputs", 32'({rsp_valid, reg_valid}), 0);
    for (int i = 0; i < 16; i++) acc(0, 0, 0, 5'(i), 0, "R1 reset byte");
    prom_we = 1;
    for (int i = 0; i < 16; i++) acc(0, 1, 0, 5'(i), 32'(8'h30 + i * 7), "R2 preload byte");
    for (int i = 0; i < 16; i++) acc(0, 0, 0, 5'(i), 0, "R2 byte read");
    acc(0, 0, 1, 5'd2, 0, "R6 io half");
    acc(0, 0, 1, 5'd3, 0, "R2 odd half ones");
    acc(0, 1, 1, 5'd5, 32'h0000AAAA, "R2 odd half write dropped");
    acc(0, 0, 1, 5'd4, 0, "R2 even half after drop");
    acc(0, 0, 2, 5'd0, 0, "R5 word without dword ones");
    acc(0, 1, 1, 5'd6, 32'h00001234, "R2 even half write");
    acc(0, 0, 1, 5'd6, 0, "R6 half readback");
    dword_mode = 1;
    acc(0, 0, 2, 5'd8, 0, "R3 aligned word");
    acc(0, 0, 0, 5'd8, 0, "R3 byte ones");
    acc(0, 0, 1, 5'd8, 0, "R3 half ones");
    acc(0, 0, 2, 5'd9, 0, "R3 misaligned ones");
    acc(0, 1, 0, 5'd8, 32'h000000EE, "R3 byte write dropped");
    acc(0, 1, 2, 5'd12, 32'hDDCCBBAA, "R3 word write");
    acc(0, 0, 2, 5'd12, 0, "R6 word readback");
    acc(1, 0, 0, 5'd13, 0, "R8 mmio byte ignores mode");
    prom_we = 0;
    acc(1, 1, 2, 5'd0, 32'h11223344, "R4 locked write");
    acc(1, 0, 2, 5'd0, 0, "R4 read while locked");
    acc(0, 1, 2, 5'd4, 32'h55667788, "R4 locked io write");
    acc(0, 0, 2, 5'd4, 0, "R4 io read while locked");
    dword_mode = 0;
    prom_we = 1;
    acc(1, 1, 1, 5'd15, 32'h00009988, "R8 mmio half wrap write");
    acc(1, 0, 1, 5'd15, 0, "R8 mmio half wrap read");
    acc(1, 0, 2, 5'd1, 0, "R8 mmio unaligned word");
    acc(1, 0, 0, 5'd0, 0, "R8 mmio byte at 0");
    acc(0, 0, 1, 5'h12, 0, "R7 io reg half");
    acc(0, 1, 2, 5'h14, 32'h0BADF00D, "R7 io reg word write");
    acc(0, 0, 0, 5'h14, 0, "R7 io reg byte ones");
    acc(0, 1, 0, 5'h11, 32'h000000FF, "R7 io reg byte write dropped");
    acc(1, 0, 2, 5'h13, 0, "R8 mmio reg word");
    acc(1, 1, 1, 5'h1E, 32'h0000CAFE, "R8 mmio reg half write");
    acc(1, 0, 0, 5'h11, 0, "R8 mmio reg byte ones");
    acc(1, 0, 3, 5'h02, 0, "R5 bad size ones");
    for (int i = 0; i < 16; i++) acc(1, 0, 0, 5'(i), 0, "R5 final contents");
    @(negedge clk);
    chk(rsp_valid == 0, "R9 idle no rsp", 32'(rsp_valid), 0);
    done = 1;
    $display("CHECKS %0d ERRORS %0d", checks, errors);
    $finish;
  end
endmodule